// File: doc/BRIEF.md
# Three-Wire Synthesizer Configuration Loader

This block takes configuration words for a frequency synthesizer from a three-wire serial link: a data line, a serial clock and a load strobe. All three lines are brought into the system clock domain through a synchronizer. Each rising edge of the serial clock shifts one bit into a 19-bit shift register. A rising edge of the load strobe then commits the word to one of two holding sets. The last bit shifted in is a routing bit, and it picks the set.

The reference set holds a 14-bit reference divide value and four single-bit mode flags: prescaler modulus select, phase polarity, monitor output select and pump current select. The divider set holds a 7-bit swallow count and an 11-bit main count. The block discards a word that arrives with the wrong number of bits, and also a reference word whose divide value is illegal. In both cases it raises an error flag. A valid flag tells downstream logic when both sets hold written values.

Top module: `scfg_loader`

## Requirements
- R1: After reset, every held field is zero, and both `cfgValid` and `frameErr` are low.
- R2: Bits are sent most significant first, and exactly 19 serial clock rises form a word. Counting from the last bit shifted in as position 1 up to the first bit sent as position 19, position 1 is the routing bit.
- R3: A routing bit of 1 loads the reference set. Positions 2..15 give `refDiv`, with position 2 as its LSB. Position 16 gives `prescSel`, 17 gives `phasePol`, 18 gives `monSel` and 19 gives `pumpHi`.
- R4: A routing bit of 0 loads the divider set. Positions 2..8 give `swallowCnt` (position 2 is the LSB) and positions 9..19 give `mainCnt` (position 9 is the LSB).
- R5: Loading one set leaves every field of the other set unchanged.
- R6: The held fields change only when the load strobe rises. Bits shifted in before that rise leave the outputs unchanged.
- R7: Serial clock rises that arrive while the load strobe is high are neither shifted nor counted.
- R8: A word committed with any count of serial clock rises other than 19 since the previous load strobe rise is discarded, and `frameErr` goes high.
- R9: A reference word whose divide value is below 3 is discarded, and `frameErr` goes high.
- R10: A word that is accepted clears `frameErr`.
- R11: `cfgValid` rises only once both sets have been loaded at least once, and after that it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial bit clock (asynchronous) |
| serData | input | 1 | Serial data, MSB first |
| serLoad | input | 1 | Load strobe; commit happens on its rising edge |
| refDiv | output | 14 | Reference divide value |
| prescSel | output | 1 | Prescaler modulus select flag |
| phasePol | output | 1 | Phase comparator polarity flag |
| monSel | output | 1 | Monitor/lock output select flag |
| pumpHi | output | 1 | Charge pump high-current flag |
| swallowCnt | output | 7 | Swallow counter value |
| mainCnt | output | 11 | Main counter value |
| cfgValid | output | 1 | Both sets written since reset |
| frameErr | output | 1 | Last committed word was discarded |

## Verification
The bench builds the block with its default widths: a 14-bit reference field, a 7-bit swallow field, an 11-bit main field and a two-stage synchronizer. These widths give the 19-bit word, so the table can hit the field extremes directly: divide values of 3 and 16383, a swallow count of 0 and 127, and a main count of 2047. Because the word length is short, the bench can send words one bit short and one bit long. It can also send clock pulses while the strobe is high, and a reference value of 2, which sits just below the legal floor.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
  // strobes from the control unit to the datapath
  typedef struct packed {
    logic shiftEn;   // push shiftBit into the shift register
    logic shiftBit;  // synchronized data level
    logic latchReq;  // load strobe rose this cycle
    logic countOk;   // exactly one word of bits seen since last load
  } scfgStrobe_t;
endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[g] <= '0;
      else       stage[g] <= stage[g-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/scfg_ctrl.sv
module scfg_ctrl
  import scfg_pkg::*;
#(
  parameter int FRAME_BITS  = 19,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        serClk,
  input  logic        serData,
  input  logic        serLoad,
  output scfgStrobe_t strobe
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_WORD = CNT_W'(FRAME_BITS);

  logic [2:0] syncLvl;   // {load, data, clock}
  logic [2:0] prevLvl;
  logic [CNT_W-1:0] bitCnt;
  logic sclkRise, loadRise;

  scfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({serLoad, serData, serClk}),
    .dout(syncLvl)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= '0;
    else       prevLvl <= syncLvl;
  end

  always_comb begin
    sclkRise = syncLvl[0] & ~prevLvl[0];
    loadRise = syncLvl[2] & ~prevLvl[2];
  end

  // saturating bit counter, restarted by each load strobe rise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                bitCnt <= '0;
    else if (loadRise)                        bitCnt <= '0;
    else if (strobe.shiftEn && bitCnt != CNT_SAT) bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    strobe.shiftEn  = sclkRise & ~syncLvl[2];
    strobe.shiftBit = syncLvl[1];
    strobe.latchReq = loadRise;
    strobe.countOk  = (bitCnt == CNT_WORD);
  end
endmodule

// File: rtl/scfg_datapath.sv
module scfg_datapath
  import scfg_pkg::*;
#(
  parameter int REF_W   = 14,
  parameter int SWAL_W  = 7,
  parameter int MAIN_W  = 11,
  parameter int REF_MIN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  scfgStrobe_t       strobe,
  output logic [REF_W-1:0]  refDiv,
  output logic [3:0]        refFlags,   // {pump, monitor, polarity, prescaler}
  output logic [SWAL_W-1:0] swallowCnt,
  output logic [MAIN_W-1:0] mainCnt,
  output logic              cfgValid,
  output logic              frameErr
);
  localparam int FRAME_BITS = 1 + REF_W + 4;
  localparam int FLAG_LO    = REF_W + 1;
  localparam int MAIN_LO    = SWAL_W + 1;

  logic [FRAME_BITS-1:0] shiftReg;
  logic [REF_W-1:0]  refField;
  logic [3:0]        flagField;
  logic [SWAL_W-1:0] swalField;
  logic [MAIN_W-1:0] mainField;
  logic routeRef, refOk, refSeen, divSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= {shiftReg[FRAME_BITS-2:0], strobe.shiftBit};
  end

  always_comb begin
    routeRef  = shiftReg[0];
    refField  = shiftReg[REF_W:1];
    flagField = shiftReg[FLAG_LO+3:FLAG_LO];
    swalField = shiftReg[SWAL_W:1];
    mainField = shiftReg[MAIN_LO+MAIN_W-1:MAIN_LO];
    refOk     = refField >= REF_W'(REF_MIN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refDiv     <= '0;
      refFlags   <= '0;
      swallowCnt <= '0;
      mainCnt    <= '0;
      refSeen    <= 1'b0;
      divSeen    <= 1'b0;
      frameErr   <= 1'b0;
    end else if (strobe.latchReq) begin
      if (!strobe.countOk) begin
        frameErr <= 1'b1;
      end else if (routeRef) begin
        if (refOk) begin
          refDiv   <= refField;
          refFlags <= flagField;
          refSeen  <= 1'b1;
          frameErr <= 1'b0;
        end else begin
          frameErr <= 1'b1;
        end
      end else begin
        swallowCnt <= swalField;
        mainCnt    <= mainField;
        divSeen    <= 1'b1;
        frameErr   <= 1'b0;
      end
    end
  end

  assign cfgValid = refSeen & divSeen;
endmodule

// File: rtl/scfg_loader.sv
module scfg_loader
  import scfg_pkg::*;
#(
  parameter int REF_W       = 14,
  parameter int SWAL_W      = 7,
  parameter int MAIN_W      = 11,
  parameter int REF_MIN     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              serLoad,
  output logic [REF_W-1:0]  refDiv,
  output logic              prescSel,
  output logic              phasePol,
  output logic              monSel,
  output logic              pumpHi,
  output logic [SWAL_W-1:0] swallowCnt,
  output logic [MAIN_W-1:0] mainCnt,
  output logic              cfgValid,
  output logic              frameErr
);
  // both word formats must share one length: 1 + REF_W + 4 == 1 + SWAL_W + MAIN_W
  localparam int FRAME_BITS = 1 + REF_W + 4;

  scfgStrobe_t strobe;
  logic [3:0]  refFlags;

  scfg_ctrl #(.FRAME_BITS(FRAME_BITS), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .serClk (serClk),
    .serData(serData),
    .serLoad(serLoad),
    .strobe (strobe)
  );

  scfg_datapath #(.REF_W(REF_W), .SWAL_W(SWAL_W), .MAIN_W(MAIN_W), .REF_MIN(REF_MIN)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .refDiv    (refDiv),
    .refFlags  (refFlags),
    .swallowCnt(swallowCnt),
    .mainCnt   (mainCnt),
    .cfgValid  (cfgValid),
    .frameErr  (frameErr)
  );

  assign {pumpHi, monSel, phasePol, prescSel} = refFlags;
endmodule

// File: rtl/scfg_loader_chk.sv
module scfg_loader_chk #(
  parameter int REF_W   = 14,
  parameter int SWAL_W  = 7,
  parameter int MAIN_W  = 11,
  parameter int REF_MIN = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [REF_W-1:0]  refDiv,
  input logic              prescSel,
  input logic              phasePol,
  input logic              monSel,
  input logic              pumpHi,
  input logic [SWAL_W-1:0] swallowCnt,
  input logic [MAIN_W-1:0] mainCnt,
  input logic              cfgValid,
  input logic              frameErr
);
  logic [REF_W+3:0]         refSet;
  logic [SWAL_W+MAIN_W-1:0] divSet;
  assign refSet = {refDiv, pumpHi, monSel, phasePol, prescSel};
  assign divSet = {swallowCnt, mainCnt};

  p_valid_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |=> cfgValid);

  p_valid_after_ref_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgValid) |-> refDiv >= REF_W'(REF_MIN));

  p_ref_legal_r9: assert property (@(posedge clk) disable iff (!rstN)
    (refDiv == '0) || (refDiv >= REF_W'(REF_MIN)));

  p_sets_exclusive_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(refSet) |-> $stable(divSet));

  p_discard_on_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameErr) |-> ($stable(refSet) && $stable(divSet)));

  p_update_clears_err_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(refSet) || !$stable(divSet)) |-> !frameErr);
endmodule

bind scfg_loader scfg_loader_chk #(
  .REF_W(REF_W), .SWAL_W(SWAL_W), .MAIN_W(MAIN_W), .REF_MIN(REF_MIN)
) u_chk (.*);

// File: tb/test_scfg_loader.sv
`timescale 1ns/1ps
module test_scfg_loader;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serLoad = 1'b0;
  logic [13:0] refDiv;
  logic prescSel, phasePol, monSel, pumpHi;
  logic [6:0]  swallowCnt;
  logic [10:0] mainCnt;
  logic cfgValid, frameErr;

  always #2.5 clk = ~clk;

  scfg_loader i_scfg_loader (.*);

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  // model state
  logic [13:0] mRef = '0;
  logic [3:0]  mFlags = '0;   // {pump, monitor, polarity, prescaler}
  logic [6:0]  mSwal = '0;
  logic [10:0] mMain = '0;
  bit refSeen = 0, divSeen = 0;

  typedef struct packed {
    logic        isRef;
    logic [13:0] wide;    // reference value, or main count in [10:0]
    logic [6:0]  swal;
    logic [3:0]  flags;   // [0] prescaler, [1] polarity, [2] monitor, [3] pump
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 14'd3,      7'd0,    4'b0101},
    '{1'b0, 14'd2047,   7'd0,    4'b0000},
    '{1'b1, 14'd16383,  7'd0,    4'b1010},
    '{1'b0, 14'd3,      7'd127,  4'b0000},
    '{1'b1, 14'h1555,   7'd0,    4'b1111},
    '{1'b0, 14'h02AA,   7'h55,   4'b0000}
  };

  // index k-1 holds position k (position 1 = routing bit)
  function automatic logic [18:0] mkFrame(vec_t v);
    logic [18:0] f = '0;
    f[0] = v.isRef;
    if (v.isRef) begin
      f[14:1] = v.wide;
      f[15] = v.flags[0];
      f[16] = v.flags[1];
      f[17] = v.flags[2];
      f[18] = v.flags[3];
    end else begin
      f[7:1]  = v.swal;
      f[18:8] = v.wide[10:0];
    end
    return f;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req, input bit expErr);
    chk({refDiv, pumpHi, monSel, phasePol, prescSel} == {mRef, mFlags}, req,
        {refDiv, pumpHi, monSel, phasePol, prescSel}, {mRef, mFlags});
    chk({swallowCnt, mainCnt} == {mSwal, mMain}, req, {swallowCnt, mainCnt}, {mSwal, mMain});
    chk(cfgValid == (refSeen && divSeen), {req, " R11 valid"}, cfgValid, refSeen && divSeen);
    chk(frameErr == expErr, {req, " err flag"}, frameErr, expErr);
  endtask

  task automatic sendBit(input logic b);
    serData = b;
    repeat (3) @(negedge clk);
    serClk = 1'b1;
    repeat (3) @(negedge clk);
    serClk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendBits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) sendBit(w[i]);
  endtask

  task automatic pulseLoad();
    serLoad = 1'b1;
    repeat (4) @(negedge clk);
    serLoad = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic applyModel(vec_t v);
    if (v.isRef) begin mRef = v.wide; mFlags = v.flags; refSeen = 1; end
    else begin mMain = v.wide[10:0]; mSwal = v.swal; divSeen = 1; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    vec_t v;
    repeat (4) @(negedge clk);
    // R1: reset state
    checkAll("R1 reset", 1'b0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    checkAll("R1 after release", 1'b0);

    // table walk: R2 R3 R4 R5 R10 R11
    for (int k = 0; k < 6; k++) begin
      sendBits({13'd0, mkFrame(VECS[k])}, 19);
      pulseLoad();
      applyModel(VECS[k]);
      checkAll(VECS[k].isRef ? "R3 R5 ref load" : "R4 R5 div load", 1'b0);
    end

    // R8: one bit short, then one bit long
    sendBits({13'd0, mkFrame('{1'b1, 14'd100, 7'd0, 4'b0011})} >> 1, 18);
    pulseLoad();
    checkAll("R8 short word", 1'b1);
    sendBits({13'd0, mkFrame('{1'b0, 14'd9, 7'd9, 4'b0000})}, 20);
    pulseLoad();
    checkAll("R8 long word", 1'b1);

    // R10: good word clears the error
    v = '{1'b0, 14'd1000, 7'd42, 4'b0000};
    sendBits({13'd0, mkFrame(v)}, 19);
    pulseLoad();
    applyModel(v);
    checkAll("R10 clear err", 1'b0);

    // R9: reference value 2 rejected
    sendBits({13'd0, mkFrame('{1'b1, 14'd2, 7'd0, 4'b1111})}, 19);
    pulseLoad();
    checkAll("R9 ref below floor", 1'b1);

    // R6: shifted bits without a strobe leave outputs alone
    v = '{1'b1, 14'd777, 7'd0, 4'b0110};
    sendBits({13'd0, mkFrame(v)}, 19);
    repeat (6) @(negedge clk);
    checkAll("R6 no strobe yet", 1'b1);
    pulseLoad();
    applyModel(v);
    checkAll("R6 after strobe", 1'b0);

    // R7: clock pulses while strobe high are ignored
    v = '{1'b0, 14'd5, 7'd3, 4'b0000};
    sendBits({13'd0, mkFrame(v)}, 19);
    serLoad = 1'b1;
    repeat (4) @(negedge clk);
    sendBits(32'h7, 3);
    serLoad = 1'b0;
    repeat (6) @(negedge clk);
    applyModel(v);
    checkAll("R7 first word", 1'b0);
    v = '{1'b0, 14'd1234, 7'd100, 4'b0000};
    sendBits({13'd0, mkFrame(v)}, 19);
    pulseLoad();
    applyModel(v);
    checkAll("R7 edges under strobe not counted", 1'b0);

    // R11: after reset, one set alone does not raise valid
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mRef = '0; mFlags = '0; mSwal = '0; mMain = '0; refSeen = 0; divSeen = 0;
    checkAll("R1 second reset", 1'b0);
    v = '{1'b0, 14'd77, 7'd1, 4'b0000};
    sendBits({13'd0, mkFrame(v)}, 19);
    pulseLoad();
    applyModel(v);
    checkAll("R11 divider only", 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule